// File: doc/BRIEF.md
# Interrupt Capture and End-of-Interrupt Unit

This unit gathers 32 interrupt request lines for a small processor core and decides when the core should branch to its single interrupt handler. The three lowest request numbers can also be raised by internal event inputs, which are merged with the external lines. Requests are held in a pending register until the core reports an instruction boundary while no handler is running. At that point the unit tells the core to redirect and records two values. The first is the address the core would have run next. The second is the whole pending mask, so one handler pass can service several interrupts.

While the handler runs, one end-of-interrupt output per captured interrupt stays high. All of them drop when the core signals the handler's return. The core can also read and write four 32-bit handler registers through a small select/data port. Slots 0 and 1 hold the saved address and mask. Slots 2 and 3 are free scratch storage that hardware never initialises.

Top module: `irq_capture_unit`

## Requirements
- R1: With rst high at a clock edge, the pending mask, handler-active flag, eoi outputs and slots 0 and 1 are all cleared after that edge, and take_irq is low.
- R2: A high bit n of irq_ext, or bit k of irq_int_evt for k in 0..2, at a clock edge sets pending bit n (bit k for internal events). The bit stays set until it is captured at an entry, even after the request line falls.
- R3: take_irq is high in a cycle exactly when ENABLE is 1, boundary_stb is high, handler_active is low and at least one pending bit is set. It is high for one cycle per entry.
- R4: At the edge where take_irq is high, slot 0 is loaded with next_pc.
- R5: At the edge where take_irq is high, slot 1 is loaded with the pending mask as it was before that edge. Those bits leave the pending mask. Requests present at that same edge are kept pending for the next entry.
- R6: From the edge after an entry until a return, eoi equals the mask captured in slot 1 and handler_active is high. While no handler is active, eoi is all zero.
- R7: ret_stb high while handler_active is high clears handler_active and all eoi bits at that edge. ret_stb while idle has no effect.
- R8: No entry occurs while a handler is active. Requests that arrive during the handler stay pending and trigger the next entry after the return.
- R9: reg_rd_sel values 0, 1, 2 and 3 select slots 0, 1, 2 and 3 on reg_rd_data, combinationally. A write with reg_wr_en high stores reg_wr_data into slot reg_wr_sel at the edge. When an entry happens at the same edge, the entry's values win for slots 0 and 1.
- R10: With ENABLE set to 0, take_irq and all eoi bits stay 0 whatever the requests are. Register slot access still works.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_ext | input | 32 | External interrupt request lines, bit n requests interrupt n |
| irq_int_evt | input | 3 | Internal event sources merged into request bits 0..2 |
| boundary_stb | input | 1 | Core is at an instruction boundary this cycle |
| next_pc | input | 32 | Address the core would execute next |
| ret_stb | input | 1 | Core executes the handler return this cycle |
| take_irq | output | 1 | One-cycle redirect to the handler |
| handler_active | output | 1 | Handler is running |
| eoi | output | 32 | Per-interrupt end-of-interrupt lines |
| reg_wr_en | input | 1 | Handler register write strobe |
| reg_wr_sel | input | 2 | Slot written |
| reg_wr_data | input | 32 | Write data |
| reg_rd_sel | input | 2 | Slot read |
| reg_rd_data | output | 32 | Read data of the selected slot |

## Verification
A pending bit that is wrongly lost or wrongly kept shows up in the mask read from slot 1 and on eoi, one edge after the next entry. It can stay hidden until a boundary strobe arrives with no handler running. A stuck or missing active flag shows in the same cycle: take_irq either fires during a handler or fails to fire when it should. eoi also stops holding steady between entry and return. Saved address errors are visible on reg_rd_data in the cycle after entry.

// File: rtl/irqcap_pkg.sv
package irqcap_pkg;
  localparam int IRQ_LINES = 32;
  localparam int XLEN      = 32;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  typedef logic [IRQ_LINES-1:0] irq_vec_t;
  typedef logic [XLEN-1:0]      word_t;

  // pending update: captured bits leave, new requests join in the same edge
  function automatic irq_vec_t pending_next(irq_vec_t cur, irq_vec_t req, logic take);
    irq_vec_t kept;
    kept = take ? '0 : cur;
    return kept | req;
  endfunction

  // entry decision
  function automatic logic entry_ok(logic en, logic bnd, logic act, irq_vec_t pend);
    return en && bnd && !act && (|pend);
  endfunction
endpackage

// File: rtl/irq_request_merge.sv
module irq_request_merge
  import irqcap_pkg::*;
#(
  parameter int  LINES   = IRQ_LINES,
  parameter int  NUM_INT = 3,
  parameter bit  ENABLE  = 1'b1
) (
  input  logic [LINES-1:0]   ext_req,
  input  logic [NUM_INT-1:0] int_evt,
  output logic [LINES-1:0]   req_vec
);
  logic [LINES-1:0] merged;

  for (genvar n = 0; n < LINES; n++) begin : g_bit
    if (n < NUM_INT) begin : g_int
      assign merged[n] = ext_req[n] | int_evt[n];
    end else begin : g_ext
      assign merged[n] = ext_req[n];
    end
  end

  if (ENABLE) begin : g_on
    assign req_vec = merged;
  end else begin : g_off
    assign req_vec = '0;
  end
endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg
  import irqcap_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  irq_vec_t req_vec,
  input  logic     take,
  output irq_vec_t pending
);
  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else     pending <= pending_next(pending, req_vec, take);
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irqcap_pkg::*;
#(
  parameter bit ENABLE = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     boundary_stb,
  input  logic     ret_stb,
  input  irq_vec_t pending,
  output logic     take,
  output logic     active,
  output irq_vec_t eoi_q
);
  logic ret_ev;

  assign take   = entry_ok(ENABLE, boundary_stb, active, pending);
  assign ret_ev = ret_stb && active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      eoi_q  <= '0;
    end else if (take) begin
      active <= 1'b1;
      eoi_q  <= pending;
    end else if (ret_ev) begin
      active <= 1'b0;
      eoi_q  <= '0;
    end
  end
endmodule

// File: rtl/irq_slot_bank.sv
module irq_slot_bank
  import irqcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  word_t             ret_addr,
  input  irq_vec_t          cap_mask,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_sel,
  input  word_t             wr_data,
  input  logic [SLOT_W-1:0] rd_sel,
  output word_t             rd_data,
  output word_t             slot0,
  output word_t             slot1
);
  word_t slots [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic sw_hit;
    assign sw_hit = wr_en && (wr_sel == SLOT_W'(i));
    if (i == 0) begin : g_addr
      always_ff @(posedge clk) begin
        if (rst)         slots[i] <= '0;
        else if (take)   slots[i] <= ret_addr;
        else if (sw_hit) slots[i] <= wr_data;
      end
    end else if (i == 1) begin : g_mask
      always_ff @(posedge clk) begin
        if (rst)         slots[i] <= '0;
        else if (take)   slots[i] <= word_t'(cap_mask);
        else if (sw_hit) slots[i] <= wr_data;
      end
    end else begin : g_tmp
      always_ff @(posedge clk) begin
        if (sw_hit) slots[i] <= wr_data;
      end
    end
  end

  assign rd_data = slots[rd_sel];
  assign slot0   = slots[0];
  assign slot1   = slots[1];
endmodule

// File: rtl/irq_capture_unit.sv
module irq_capture_unit
  import irqcap_pkg::*;
#(
  parameter bit ENABLE  = 1'b1,
  parameter int NUM_INT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IRQ_LINES-1:0] irq_ext,
  input  logic [NUM_INT-1:0] irq_int_evt,
  input  logic               boundary_stb,
  input  logic [XLEN-1:0]    next_pc,
  input  logic               ret_stb,
  output logic               take_irq,
  output logic               handler_active,
  output logic [IRQ_LINES-1:0] eoi,
  input  logic               reg_wr_en,
  input  logic [SLOT_W-1:0]  reg_wr_sel,
  input  logic [XLEN-1:0]    reg_wr_data,
  input  logic [SLOT_W-1:0]  reg_rd_sel,
  output logic [XLEN-1:0]    reg_rd_data
);
  irq_vec_t req_vec;
  irq_vec_t pending_q;
  word_t    ret_addr_q;
  word_t    cap_mask_q;

  irq_request_merge #(.LINES(IRQ_LINES), .NUM_INT(NUM_INT), .ENABLE(ENABLE)) u_merge (
    .ext_req (irq_ext),
    .int_evt (irq_int_evt),
    .req_vec (req_vec)
  );

  irq_pending_reg u_pend (
    .clk     (clk),
    .rst     (rst),
    .req_vec (req_vec),
    .take    (take_irq),
    .pending (pending_q)
  );

  irq_entry_ctrl #(.ENABLE(ENABLE)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .boundary_stb (boundary_stb),
    .ret_stb      (ret_stb),
    .pending      (pending_q),
    .take         (take_irq),
    .active       (handler_active),
    .eoi_q        (eoi)
  );

  irq_slot_bank u_slots (
    .clk      (clk),
    .rst      (rst),
    .take     (take_irq),
    .ret_addr (next_pc),
    .cap_mask (pending_q),
    .wr_en    (reg_wr_en),
    .wr_sel   (reg_wr_sel),
    .wr_data  (reg_wr_data),
    .rd_sel   (reg_rd_sel),
    .rd_data  (reg_rd_data),
    .slot0    (ret_addr_q),
    .slot1    (cap_mask_q)
  );
endmodule

// File: rtl/irq_capture_checker.sv
module irq_capture_checker
  import irqcap_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     take_irq,
  input logic     handler_active,
  input logic     ret_stb,
  input logic     boundary_stb,
  input irq_vec_t eoi,
  input irq_vec_t pending_q,
  input word_t    next_pc,
  input word_t    ret_addr_q,
  input word_t    cap_mask_q
);
  assert_no_nest_R8: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> (!handler_active && boundary_stb));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    take_irq |=> !take_irq);

  assert_pc_saved_R4: assert property (@(posedge clk) disable iff (rst)
    take_irq |=> (ret_addr_q == $past(next_pc)));

  assert_mask_saved_R5: assert property (@(posedge clk) disable iff (rst)
    take_irq |=> (cap_mask_q == word_t'($past(pending_q)) && handler_active));

  assert_eoi_entry_R6: assert property (@(posedge clk) disable iff (rst)
    take_irq |=> (eoi == $past(pending_q)));

  assert_eoi_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (handler_active && !ret_stb) |=> $stable(eoi));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !handler_active |-> (eoi == '0));

  assert_return_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (ret_stb && handler_active) |=> (!handler_active && eoi == '0));
endmodule

bind irq_capture_unit irq_capture_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .take_irq       (take_irq),
  .handler_active (handler_active),
  .ret_stb        (ret_stb),
  .boundary_stb   (boundary_stb),
  .eoi            (eoi),
  .pending_q      (pending_q),
  .next_pc        (next_pc),
  .ret_addr_q     (ret_addr_q),
  .cap_mask_q     (cap_mask_q)
);

// File: tb/test_irq_capture_unit.sv
module test_irq_capture_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] irq_ext;
  logic [2:0]  irq_int_evt;
  logic        boundary_stb;
  logic [31:0] next_pc;
  logic        ret_stb;
  logic        take_irq, handler_active;
  logic [31:0] eoi;
  logic        reg_wr_en;
  logic [1:0]  reg_wr_sel, reg_rd_sel;
  logic [31:0] reg_wr_data, reg_rd_data;
  logic        off_take, off_active;
  logic [31:0] off_eoi, off_rd;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  // reference state
  logic [31:0] m_pend, m_eoi;
  logic        m_act;
  logic [31:0] m_q [4];
  bit          m_valid [4];
  logic [31:0] off_q [4];
  bit          off_valid [4];

  always #4 clk = ~clk;

  irq_capture_unit i_irq_capture_unit (
    .clk(clk), .rst(rst), .irq_ext(irq_ext), .irq_int_evt(irq_int_evt),
    .boundary_stb(boundary_stb), .next_pc(next_pc), .ret_stb(ret_stb),
    .take_irq(take_irq), .handler_active(handler_active), .eoi(eoi),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data));

  irq_capture_unit #(.ENABLE(1'b0)) i_irq_capture_unit_off (
    .clk(clk), .rst(rst), .irq_ext(irq_ext), .irq_int_evt(irq_int_evt),
    .boundary_stb(boundary_stb), .next_pc(next_pc), .ret_stb(ret_stb),
    .take_irq(off_take), .handler_active(off_active), .eoi(off_eoi),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .reg_rd_sel(reg_rd_sel), .reg_rd_data(off_rd));

  function automatic logic [31:0] exp_req(logic [31:0] e, logic [2:0] iv);
    logic [31:0] r;
    r = e;
    for (int k = 0; k < 3; k++) if (iv[k]) r[k] = 1'b1;
    return r;
  endfunction

  function automatic logic exp_take();
    return boundary_stb && !m_act && (m_pend != 32'd0);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic compare();
    chk(take_irq === exp_take(), "R3 take_irq", 32'(take_irq), 32'(exp_take()));
    chk(handler_active === m_act, "R6/R7 handler_active", 32'(handler_active), 32'(m_act));
    chk(eoi === m_eoi, "R6/R7 eoi", eoi, m_eoi);
    if (reg_rd_sel < 2 || m_valid[reg_rd_sel])
      chk(reg_rd_data === m_q[reg_rd_sel], "R4/R5/R9 reg_rd_data", reg_rd_data, m_q[reg_rd_sel]);
    chk(off_take === 1'b0, "R10 take_irq disabled", 32'(off_take), 32'd0);
    chk(off_eoi === 32'd0, "R10 eoi disabled", off_eoi, 32'd0);
    if (reg_rd_sel < 2 || off_valid[reg_rd_sel])
      chk(off_rd === off_q[reg_rd_sel], "R10/R9 slots when disabled", off_rd, off_q[reg_rd_sel]);
  endtask

  // check at mid cycle, then advance model across the edge
  task automatic step();
    logic tk;
    logic [31:0] rq;
    #1;
    compare();
    tk = exp_take();
    rq = exp_req(irq_ext, irq_int_evt);
    @(posedge clk);
    if (tk) begin
      m_q[0] = next_pc;
      m_q[1] = m_pend;
      m_eoi  = m_pend;
      m_act  = 1'b1;
      m_pend = rq;
    end else begin
      m_pend = m_pend | rq;
      if (ret_stb && m_act) begin
        m_act = 1'b0;
        m_eoi = 32'd0;
      end
    end
    if (reg_wr_en && !(tk && reg_wr_sel < 2)) begin
      m_q[reg_wr_sel] = reg_wr_data;
      m_valid[reg_wr_sel] = 1;
    end
    if (reg_wr_en) begin
      off_q[reg_wr_sel] = reg_wr_data;
      off_valid[reg_wr_sel] = 1;
    end
    cycles++;
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    irq_ext = 0; irq_int_evt = 0; boundary_stb = 0; ret_stb = 0;
    reg_wr_en = 0; reg_wr_sel = 0; reg_wr_data = 0; reg_rd_sel = 1;
    next_pc = 32'h0000_1000;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected<200000", cycles);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20250611));
    idle_inputs();
    rst = 1'b1;
    m_pend = 0; m_eoi = 0; m_act = 0;
    for (int i = 0; i < 4; i++) begin
      m_q[i] = 0; m_valid[i] = 0; off_q[i] = 0; off_valid[i] = 0;
    end
    irq_ext = 32'hFFFF_FFFF; // requests during reset must be dropped
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    #1;
    chk(eoi === 0 && !handler_active, "R1 eoi/active after reset", eoi, 32'd0);
    reg_rd_sel = 0; #1;
    chk(reg_rd_data === 0, "R1 slot0 after reset", reg_rd_data, 32'd0);
    reg_rd_sel = 1; #1;
    chk(reg_rd_data === 0, "R1 slot1 after reset", reg_rd_data, 32'd0);
    chk(take_irq === 1'b0, "R1 take_irq in reset", 32'(take_irq), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    idle_inputs();

    // R2: internal events + external pulse, held in pending after lines fall
    irq_int_evt = 3'b101; irq_ext = 32'h8000_0010; step();
    idle_inputs(); repeat (2) step();
    // R3/R4/R5: boundary entry, request arriving in the entry cycle stays pending
    boundary_stb = 1; next_pc = 32'hCAFE_0100; irq_ext = 32'h0000_0200; step();
    idle_inputs(); reg_rd_sel = 0; step();
    reg_rd_sel = 1; step();
    // R8: boundary while active, no nesting
    boundary_stb = 1; irq_ext = 32'h0400_0000; step();
    // R9: scratch slots
    idle_inputs(); reg_wr_en = 1; reg_wr_sel = 2; reg_wr_data = 32'h1234_5678; step();
    reg_wr_sel = 3; reg_wr_data = 32'h9ABC_DEF0; reg_rd_sel = 2; step();
    reg_wr_en = 0; reg_rd_sel = 3; step();
    // R7: return, then second entry picks up the waiting bits
    ret_stb = 1; step();
    idle_inputs(); ret_stb = 1; step();   // R7 return while idle: no effect
    idle_inputs(); boundary_stb = 1; next_pc = 32'h0000_2468;
    reg_wr_en = 1; reg_wr_sel = 1; reg_wr_data = 32'hDEAD_BEEF; step(); // R9 entry beats write
    idle_inputs(); reg_rd_sel = 1; step();
    reg_rd_sel = 0; step();
    ret_stb = 1; step();
    idle_inputs(); boundary_stb = 1; step(); // R3 nothing pending -> no entry

    // constrained random
    for (int c = 0; c < 3000; c++) begin
      irq_ext      = ($urandom % 6 == 0) ? (32'd1 << ($urandom % 32)) | (($urandom % 4 == 0) ? $urandom : 32'd0) : 32'd0;
      irq_int_evt  = ($urandom % 8 == 0) ? 3'($urandom) : 3'd0;
      boundary_stb = ($urandom % 3 == 0);
      next_pc      = $urandom & 32'hFFFF_FFFC;
      ret_stb      = ($urandom % 7 == 0);
      reg_wr_en    = ($urandom % 5 == 0);
      reg_wr_sel   = 2'($urandom);
      reg_wr_data  = $urandom;
      reg_rd_sel   = 2'($urandom);
      step();
    end
    idle_inputs();
    step();
    finish_run();
  end
endmodule